// File: doc/BRIEF.md
# Dual-Mode Wraparound Burst Address Counter

This block produces the word address for a four-beat burst access to a synchronous memory. A load strobe starts an access. On that edge the block captures the full external address. The upper bits are held for the whole burst. The two low bits become the start offset of a 2-bit wraparound sequence.

Each later clock edge with the active-low advance input asserted moves to the next beat. The low address bits then follow one of two orders:
- Linear order: the start offset plus the beat count, modulo 4.
- Interleaved order: the start offset XOR the beat count.

In both orders the burst stays inside its aligned group of four words.

The order is chosen by a mode input, which is sampled when the burst is loaded. Low selects linear and high selects interleaved. Integration ties the pin high when it is left unconnected, so interleaved is the default. All controls are sampled on the rising clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released, `wordAddr` is 0 and `beatIdx` is 0 until the first load.
- R2: A rising edge with `loadN` low makes `wordAddr` equal to the `addrIn` sampled on that edge, and makes `beatIdx` 0, from that edge on.
- R3: When `loadN` and `advN` are both low on the same edge, the load wins: the beat index restarts at 0 and no step is taken.
- R4: A rising edge with `loadN` high and `advN` low increments `beatIdx` by one modulo 4, so beat 3 wraps to beat 0.
- R5: A rising edge with both `loadN` and `advN` high leaves `wordAddr` and `beatIdx` unchanged.
- R6: Between loads, `wordAddr[ADDR_W-1:2]` keeps the value captured at the last load, whatever the beat.
- R7: With `modeSel` = 0 at load, `wordAddr[1:0]` equals (start + `beatIdx`) mod 4, where start is `addrIn[1:0]` at load. For a start of 2 this gives 2, 3, 0, 1.
- R8: With `modeSel` = 1 at load, `wordAddr[1:0]` equals start XOR `beatIdx`. For a start of 1 this gives 1, 0, 3, 2. Tying `modeSel` to 1 selects this order.
- R9: `modeSel` is sampled only on a load edge. Changing it during a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadN | input | 1 | Active-low burst start strobe |
| advN | input | 1 | Active-low advance strobe |
| modeSel | input | 1 | Burst order: 0 linear, 1 interleaved (tie high if unused) |
| addrIn | input | ADDR_W | External start address |
| wordAddr | output | ADDR_W | Current word address |
| beatIdx | output | 2 | Beat count within the burst |

## Verification
Every start offset from 0 to 3 is loaded in each mode and advanced five times. This separates the two orders at offsets 1 and 3, where they differ, from offsets 0 and 2, where they coincide. It also shows the wrap back to the first beat.

Directed cases place a load and an advance on the same edge, insert idle edges in the middle of a burst, and flip the mode during a burst. These expose a wrong priority, a counter that runs freely, and a mode that is not latched at load.

Seeded random sequences of loads, advances and idles with random addresses and modes then compare every cycle against a bench model. This catches corruption of the upper address bits and errors in the beat count.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int OFS_W = 2;

  typedef struct packed {
    logic load;
    logic advance;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic          loadN,
  input  logic          advN,
  output burstStrobes_t strobes
);
  always_comb begin
    strobes.load    = ~loadN;
    strobes.advance = loadN & ~advN;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     strobes,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [OFS_W-1:0]  beatIdx
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [HI_W-1:0]  baseQ;
  logic [OFS_W-1:0] startQ;
  logic [OFS_W-1:0] beatQ;
  logic             modeQ;
  logic [OFS_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      startQ <= '0;
      beatQ  <= '0;
      modeQ  <= 1'b1;
    end else if (strobes.load) begin
      baseQ  <= addrIn[ADDR_W-1:OFS_W];
      startQ <= addrIn[OFS_W-1:0];
      beatQ  <= '0;
      modeQ  <= modeSel;
    end else if (strobes.advance) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  always_comb begin
    if (modeQ) lowBits = startQ ^ beatQ;
    else       lowBits = startQ + beatQ;
  end

  assign wordAddr = {baseQ, lowBits};
  assign beatIdx  = beatQ;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              advN,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [1:0]        beatIdx
);
  burstStrobes_t strobes;

  burst_ctrl u_ctrl (
    .loadN   (loadN),
    .advN    (advN),
    .strobes (strobes)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .modeSel  (modeSel),
    .addrIn   (addrIn),
    .wordAddr (wordAddr),
    .beatIdx  (beatIdx)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadN,
  input logic              advN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [1:0]        beatIdx
);
  // R2 and R3: a load edge captures the address and restarts the beat count.
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (wordAddr == $past(addrIn)) && (beatIdx == 2'd0));

  // R4: an advance edge without a load steps the beat count by one, modulo 4.
  assert_advance_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !advN) |=> beatIdx == $past(beatIdx) + 2'd1);

  // R5: an idle edge changes neither output.
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && advN) |=> $stable(wordAddr) && $stable(beatIdx));

  // R6: the upper address bits only change on a load.
  assert_upper_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> $stable(wordAddr[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadN    (loadN),
  .advN     (advN),
  .addrIn   (addrIn),
  .wordAddr (wordAddr),
  .beatIdx  (beatIdx)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadN = 1'b1;
  logic              advN = 1'b1;
  logic              modeSel = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] wordAddr;
  logic [1:0]        beatIdx;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  // Bench model of the burst state.
  logic [ADDR_W-3:0] mBase = '0;
  logic [1:0]        mStart = '0;
  logic [1:0]        mBeat = '0;
  logic              mMode = 1'b1;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .advN(advN),
    .modeSel(modeSel), .addrIn(addrIn), .wordAddr(wordAddr), .beatIdx(beatIdx)
  );

  function automatic logic [1:0] expLow(input logic [1:0] s, input logic [1:0] b,
                                        input logic m);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic check(input string tag);
    logic [ADDR_W-1:0] expAddr;
    expAddr = {mBase, expLow(mStart, mBeat, mMode)};
    chkCnt++;
    if (wordAddr !== expAddr || beatIdx !== mBeat) begin
      errCnt++;
      $display("FAIL %s: wordAddr=%h beatIdx=%0d expected wordAddr=%h beatIdx=%0d",
               tag, wordAddr, beatIdx, expAddr, mBeat);
    end
  endtask

  // Drive at the falling edge, update the model at the rising edge, sample after it.
  task automatic step(input logic ld, input logic adv, input logic md,
                      input logic [ADDR_W-1:0] a);
    @(negedge clk);
    loadN = ld; advN = adv; modeSel = md; addrIn = a;
    @(posedge clk);
    if (!ld) begin
      mBase = a[ADDR_W-1:2]; mStart = a[1:0]; mBeat = 2'd0; mMode = md;
    end else if (!adv) begin
      mBeat = mBeat + 2'd1;
    end
    #2;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    #2;
    check("R1 during reset");
    @(negedge clk); rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1, '0);
    check("R1 after reset");

    // All offsets in both modes, five advances each to show the wrap.
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b0, 1'b1, m[0], {18'h2A5C3 + 18'(s), 2'(s)});
        check("R2 load");
        for (int k = 0; k < 5; k++) begin
          step(1'b1, 1'b0, m[0], '0);
          check(m == 0 ? "R7 linear order R4" : "R8 interleaved order R4");
        end
      end
    end

    // Load and advance on the same edge.
    step(1'b0, 1'b1, 1'b0, 20'h12345);
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, 20'hABCDE);
    check("R3 load priority");

    // Idle edges in the middle of a burst.
    step(1'b1, 1'b0, 1'b1, '0);
    step(1'b1, 1'b1, 1'b1, 20'hFFFFF);
    check("R5 hold");
    step(1'b1, 1'b1, 1'b0, 20'h00000);
    check("R5 hold again");

    // Mode flipped during a burst.
    step(1'b0, 1'b1, 1'b0, 20'h0F0F1);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 1'b1, '0);
      check("R9 mode ignored mid-burst");
    end

    // Seeded random traffic.
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r < 2 ? 1'b0 : 1'b1, r < 7 ? 1'b0 : 1'b1, 1'($urandom), ADDR_W'($urandom));
      check(mMode ? "R8 random R6" : "R7 random R6");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule